// File: doc/BRIEF.md
# Multi-Threshold Pulse Edge Timer

The block watches one analog pulse through five comparator outputs. Each comparator trips at a deeper voltage than the one before it. The comparator lines arrive asynchronously, so the block first synchronises them. It then records when the shallowest comparator first asserts, using a free-running high-speed cycle counter, and captures the profile of the edges that follow.

Because the thresholds are nested, the edges arrive in a fixed order. The rising edges come first, from the shallowest threshold to the deepest. The falling edges follow, from the deepest back to the shallowest. Each of these later edges is stored as the number of cycles since the edge before it. When the shallowest comparator drops, the block packs one record: the absolute start time, the number of thresholds crossed, and the list of deltas. It writes this record into a small first-in first-out queue, where a processor pops records one at a time.

Record layout, with k counting from 0: delta slot k sits at bits [k*DW +: DW]. The count follows at bits [NSLOT*DW +: CW]. The 56-bit start time occupies the top bits. With the defaults, NSLOT is 9, DW is 8 and CW is 3, so the record is 131 bits wide.

Top module: `pulse_edge_timer`

## Requirements
- R1: Each comparator input passes through two synchronising flops. The start time in a record equals the free-running counter value two clock edges after the shallowest input (bit 0) rises. The counter is 0 in reset and increments on every clock.
- R2: The count field holds the number of thresholds the pulse crossed, from 1 to 5. It equals the number of distinct rising comparator edges seen during the pulse.
- R3: Slot 0 holds the first delta and each following slot holds the next one. The edge order is: rise of bit 1 up to the deepest crossed bit, then the fall of the deepest crossed bit down to the fall of bit 0. Each delta is the number of cycles since the previous recorded edge, with the rise of bit 0 as the first reference.
- R4: A delta larger than the 8-bit field saturates at 255.
- R5: A record is written on the cycle the fall of bit 0 is detected. A pulse crossing n thresholds fills slots 0 to 2n-2, and every higher slot is zero.
- R6: Edges detected in the same cycle are recorded in the R3 order. The first takes the elapsed delta and each of the others takes delta 0.
- R7: The queue holds 4 records in arrival order. While it is non-empty, rec_valid is 1 and rec_data shows the oldest record. Asserting rd_en for one cycle removes that record.
- R8: A record that completes while the queue is full is dropped. The overflow output then becomes 1 and stays 1 until reset.
- R9: Comparator edges seen while no pulse is open are ignored, unless they are a rise of bit 0. Such edges produce no record.
- R10: After reset, rec_valid, fifo_full and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed clock that also drives the time counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 5 | Asynchronous comparator outputs; bit 0 is the shallowest threshold |
| rd_en | input | 1 | Pop the oldest record |
| rec_valid | output | 1 | Queue holds at least one record |
| rec_data | output | 131 | Oldest record: start time, count, delta slots |
| fifo_full | output | 1 | Queue holds 4 records |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
On every cycle, the assertions check the following:
- the range of the count field and that all slots above the used ones are zero;
- that the head record holds still while nothing pops it;
- that a full queue implies a valid record;
- that the overflow flag only rises while the queue is full, and never clears.

The exact start time, the nested delta order, saturation, same-cycle edges, ignored idle edges and arrival order can only be shown by the bench's driven pulses. It compares each against values computed from the stimulus timing.

// File: rtl/pulse_edge_timer.sv
module pulse_edge_timer #(
  parameter int NTH   = 5,
  parameter int TS_W  = 56,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int NSLOT = 2*NTH-1,
  localparam int CW    = $clog2(NTH+1),
  localparam int IW    = $clog2(NSLOT+1),
  localparam int AW    = $clog2(DEPTH),
  localparam int REC_W = TS_W + CW + NSLOT*DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTH-1:0]   cmp_in,
  input  logic             rd_en,
  output logic             rec_valid,
  output logic [REC_W-1:0] rec_data,
  output logic             fifo_full,
  output logic             overflow
);

  logic [NTH-1:0]  s1, s2, s3;
  logic [TS_W-1:0] tcnt, ts_q;
  logic            active;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [IW-1:0]   idx_q, idx_n;
  logic [DW-1:0]   since;
  logic [DW-1:0]   dq [NSLOT];
  logic [DW-1:0]   dn [NSLOT];
  logic            start, done, hit;
  logic [NTH-1:0]  rise, fall;

  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
  assign start = !active && rise[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; tcnt <= '0;
    end else begin
      s1 <= cmp_in; s2 <= s1; s3 <= s2; tcnt <= tcnt + TS_W'(1);
    end

  always_comb begin
    for (int k = 0; k < NSLOT; k++) dn[k] = start ? '0 : dq[k];
    idx_n = start ? '0 : idx_q;
    cnt_n = start ? CW'(1) : cnt_q;
    hit   = start;
    done  = 1'b0;
    if (active || start) begin
      for (int i = 1; i < NTH; i++)
        if (rise[i]) begin
          if (idx_n < IW'(NSLOT)) dn[idx_n] = hit ? '0 : since;
          idx_n = idx_n + IW'(1);
          cnt_n = cnt_n + CW'(1);
          hit   = 1'b1;
        end
      for (int i = NTH-1; i >= 0; i--)
        if (fall[i]) begin
          if (idx_n < IW'(NSLOT)) dn[idx_n] = hit ? '0 : since;
          idx_n = idx_n + IW'(1);
          hit   = 1'b1;
          if (i == 0) done = 1'b1;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; ts_q <= '0; cnt_q <= '0; idx_q <= '0; since <= '0;
      for (int k = 0; k < NSLOT; k++) dq[k] <= '0;
    end else begin
      if (start) ts_q <= tcnt;
      if (done) active <= 1'b0;
      else if (start) active <= 1'b1;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      for (int k = 0; k < NSLOT; k++) dq[k] <= dn[k];
      if (hit) since <= DW'(1);
      else if (since != '1) since <= since + DW'(1);
    end

  logic [NSLOT*DW-1:0] dpack;
  for (genvar k = 0; k < NSLOT; k++) begin : g_pack
    assign dpack[k*DW +: DW] = dn[k];
  end

  logic [REC_W-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp;
  logic             push, pop, empty;

  assign empty     = (wp == rp);
  assign fifo_full = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign push      = done && !fifo_full;
  assign pop       = rd_en && !empty;
  assign rec_valid = !empty;
  assign rec_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; overflow <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      if (push) begin
        mem[wp[AW-1:0]] <= {ts_q, cnt_n, dpack};
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      if (done && fifo_full) overflow <= 1'b1;
    end

endmodule

// File: rtl/pulse_edge_timer_chk.sv
module pulse_edge_timer_chk #(
  parameter int NTH  = 5,
  parameter int TS_W = 56,
  parameter int DW   = 8,
  localparam int NSLOT = 2*NTH-1,
  localparam int CW    = $clog2(NTH+1),
  localparam int REC_W = TS_W + CW + NSLOT*DW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rec_valid,
  input logic [REC_W-1:0] rec_data,
  input logic             fifo_full,
  input logic             overflow
);

  logic [CW-1:0] n_f;
  logic          tail_ok;
  assign n_f = rec_data[NSLOT*DW +: CW];

  always_comb begin
    tail_ok = 1'b1;
    for (int k = 0; k < NSLOT; k++)
      if (k >= 2*int'(n_f)-1 && rec_data[k*DW +: DW] != '0) tail_ok = 1'b0;
  end

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (n_f >= CW'(1) && n_f <= CW'(NTH)));
  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> tail_ok);
  assert_head_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rd_en) |=> (rec_valid && $stable(rec_data)));
  assert_full_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rec_valid);
  assert_sticky_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fifo_full));

endmodule

bind pulse_edge_timer pulse_edge_timer_chk #(.NTH(NTH), .TS_W(TS_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rec_valid(rec_valid),
  .rec_data(rec_data), .fifo_full(fifo_full), .overflow(overflow));

// File: tb/pulse_edge_timer_bench.sv
module pulse_edge_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NTH = 5, TS_W = 56, DW = 8, DEPTH = 4;
  localparam int NSLOT = 2*NTH-1, CW = 3, REC_W = TS_W + CW + NSLOT*DW;
  localparam int NV = 6;
  localparam int VN [NV] = '{1, 3, 5, 4, 2, 3};
  localparam int VG [NV][NSLOT] = '{
    '{7, 0, 0, 0, 0, 0, 0, 0, 0},
    '{3, 4, 10, 2, 5, 0, 0, 0, 0},
    '{1, 2, 3, 4, 20, 5, 6, 7, 8},
    '{300, 2, 1, 400, 9, 3, 2, 0, 0},
    '{0, 6, 4, 0, 0, 0, 0, 0, 0},
    '{2, 3, 5, 0, 0, 0, 0, 0, 0}};

  logic clk = 0, rst_n = 0, rd_en = 0;
  logic [NTH-1:0] cmp_in = '0;
  logic rec_valid, fifo_full, overflow;
  logic [REC_W-1:0] rec_data;
  longint bcyc;
  int checks = 0, fails = 0;

  pulse_edge_timer u_pulse_edge_timer (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .rd_en(rd_en),
    .rec_valid(rec_valid), .rec_data(rec_data), .fifo_full(fifo_full), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcyc <= 0; else bcyc <= bcyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cmp_in = '0; rd_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic drive_pulse(input int n, input int g[NSLOT], output longint t0);
    int j;
    t0 = bcyc;
    cmp_in[0] = 1'b1;
    j = 0;
    for (int i = 1; i < n; i++) begin
      repeat (g[j]) @(negedge clk);
      j++;
      cmp_in[i] = 1'b1;
    end
    for (int i = n-1; i >= 0; i--) begin
      repeat (g[j]) @(negedge clk);
      j++;
      cmp_in[i] = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pop();
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    longint t0;
    longint tq [DEPTH+1];
    int gz [NSLOT];
    do_reset();
    check("R10 rec_valid", rec_valid, 0);
    check("R10 fifo_full", fifo_full, 0);
    check("R10 overflow", overflow, 0);

    for (int v = 0; v < NV; v++) begin
      drive_pulse(VN[v], VG[v], t0);
      check("R5 record present", rec_valid, 1);
      check("R1 start time", longint'(rec_data[REC_W-1 -: TS_W]), t0 + 2);
      check("R2 count", rec_data[NSLOT*DW +: CW], VN[v]);
      for (int k = 0; k < NSLOT; k++) begin
        int e;
        e = (k < 2*VN[v]-1) ? ((VG[v][k] > 255) ? 255 : VG[v][k]) : 0;
        if (v == 3 || v == 4 || v == 5)
          check("R3 R4 R6 delta", rec_data[k*DW +: DW], e);
        else
          check("R3 R5 delta", rec_data[k*DW +: DW], e);
      end
      pop();
      check("R7 pop empties", rec_valid, 0);
    end

    cmp_in[2] = 1; repeat (4) @(negedge clk);
    cmp_in[1] = 1; repeat (3) @(negedge clk);
    cmp_in[2] = 0; repeat (2) @(negedge clk);
    cmp_in[1] = 0; repeat (6) @(negedge clk);
    check("R9 idle edges ignored", rec_valid, 0);

    gz = '{3, 0, 0, 0, 0, 0, 0, 0, 0};
    for (int p = 0; p <= DEPTH; p++) begin
      drive_pulse(1, gz, t0);
      tq[p] = t0 + 2;
      if (p < DEPTH) check("R8 no overflow before full", overflow, 0);
    end
    check("R7 full", fifo_full, 1);
    check("R8 overflow set", overflow, 1);
    for (int p = 0; p < DEPTH; p++) begin
      check("R7 order", longint'(rec_data[REC_W-1 -: TS_W]), tq[p]);
      pop();
    end
    check("R8 fifth dropped", rec_valid, 0);
    check("R8 overflow sticky", overflow, 1);

    do_reset();
    check("R10 overflow cleared", overflow, 0);
    check("R10 valid cleared", rec_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule